// File: doc/BRIEF.md
# Prefixed Register-Move Datapath

This block carries out one register-to-register move inside a register file of 16 modules with 32 slots each. Each slot is either absent, an 8-bit register or a 16-bit register, and has its own set of implemented bits. A move names a source and a destination, each given as a 4-bit module number and a 5-bit slot index. The block reads the source, converts it to the destination's width, and writes the result. A move that reaches an absent slot follows fixed substitution rules.

A one-shot prefix byte is loaded through its own input. It is visible only to a move accepted on the very next clock. It supplies the upper byte whenever an 8-bit value is widened, and also the upper byte of the word that stands in for a missing source. Some slots need two cycles to reach. A prefix load in the cycle just before such a move counts as that move's first cycle. Without that load, the block inserts a stall cycle itself.

The layout of the file is fixed at elaboration by parameters. Every register powers up with a value computed from its address, so moves have nonzero data to carry. Each move ends with a one-cycle completion pulse. The same pulse presents the word that was sent toward the destination.

Top module: `regmove_unit`

## Requirements
- R1: Reset state: mv_done is 0 and mv_ready is 1. Every defined register holds ((0x5A3C + 0x0111*module + 0x1013*index) mod 65536), kept to its low byte if the register is 8-bit and then ANDed with its implemented-bit mask. Absent slots read 0. The prefix is 0.
- R2: A move between two 8-bit registers, or between two 16-bit registers, copies the source into the destination bit for bit, subject only to the destination mask.
- R3: An 8-bit source moved to a 16-bit destination writes the source byte into bits 7:0 and the prefix into bits 15:8.
- R4: A 16-bit source moved to an 8-bit destination writes only bits 7:0 of the source.
- R5: Implemented-bit masks apply in the default layout. Slots whose index mod 4 equals 3 have mask 0x7FF7 when 16-bit and 0x7E when 8-bit. All other slots are fully implemented. Bits outside the mask read 0 and ignore writes.
- R6: A move whose destination slot is absent changes no register. It still completes and presents the source word on mv_data.
- R7: An absent source supplies {prefix, 0x00} if its module contains at least one 8-bit register. It supplies 0x0000 if its module holds only 16-bit registers.
- R8: mv_data is the word sent toward the destination, before the destination's width and mask are applied. An 8-bit source appears as {prefix, byte}. A move needs two cycles when its destination index is 8 or more, or its source index is 16 or more. Otherwise it needs one. A one-cycle move pulses mv_done in the cycle after it is accepted. A two-cycle move that is not preceded by a prefix load holds mv_ready low for one cycle and pulses mv_done one cycle later.
- R9: A two-cycle move accepted in the cycle right after a prefix load completes in one cycle.
- R10: The prefix affects only the move accepted in the cycle immediately after the load. Any later move, or a move that stalls, sees a prefix of 0.
- R11: Default layout. Modules 0 to 5 are mixed: even indices are 8-bit, odd indices are 16-bit, and indices 24 to 31 are absent. Modules 6 to 9 are all 16-bit, with indices 20 to 31 absent. Modules 10 to 15 are all 8-bit, with indices 28 to 31 absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_we | input | 1 | Load the prefix byte this cycle |
| pfx_din | input | 8 | Prefix byte to load |
| mv_valid | input | 1 | Request a move; accepted when mv_ready is high |
| src_mod | input | 4 | Source module number |
| src_idx | input | 5 | Source slot index |
| dst_mod | input | 4 | Destination module number |
| dst_idx | input | 5 | Destination slot index |
| mv_ready | output | 1 | High when a new move can be accepted |
| mv_done | output | 1 | One-cycle pulse marking the end of a move |
| mv_data | output | 16 | Word sent toward the destination, valid with mv_done |

## Verification
The assertions check on every cycle that a stall cycle is always followed by a completion and by a ready block. They also check that absent slots and unimplemented bits read as zero, that widening puts the prefix byte on top, and that the prefix is zero whenever it is not live. Only the bench's scenarios can show the actual data paths and the cycle counts. These include the per-width conversions, the choice of substitute word for an absent source, the absorption of the first cycle by a prefix load, and the expiry of the prefix after a one-cycle gap. A behavioural model, compared on every clock, covers done, ready and data timing across all the scenarios.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

  typedef struct packed {
    logic        defd;
    logic        wide;
    logic [15:0] mask;
  } reg_attr_t;

  function automatic reg_attr_t attr_of(
    input int          m,
    input int          i,
    input logic [15:0] wide_mods,
    input logic [15:0] narrow_mods,
    input int          lim_mixed,
    input int          lim_wide,
    input int          lim_narrow,
    input logic [15:0] pmask16,
    input logic [7:0]  pmask8
  );
    reg_attr_t a;
    int        lim;
    logic      part;
    if (wide_mods[m[3:0]]) begin
      a.wide = 1'b1;
      lim    = lim_wide;
    end else if (narrow_mods[m[3:0]]) begin
      a.wide = 1'b0;
      lim    = lim_narrow;
    end else begin
      a.wide = i[0];
      lim    = lim_mixed;
    end
    a.defd = (i < lim);
    part   = ((i % 4) == 3);
    if (!a.defd)
      a.mask = 16'h0000;
    else if (a.wide)
      a.mask = part ? pmask16 : 16'hFFFF;
    else
      a.mask = {8'h00, (part ? pmask8 : 8'hFF)};
    return a;
  endfunction

  function automatic logic [15:0] init_of(
    input int          m,
    input int          i,
    input logic [15:0] seed
  );
    logic [31:0] t;
    t = 32'(seed) + 32'(m) * 32'h0111 + 32'(i) * 32'h1013;
    return t[15:0];
  endfunction

endpackage

// File: rtl/regmove_attr.sv
module regmove_attr
  import regmove_pkg::*;
#(
  parameter int          MOD_W       = 4,
  parameter int          IDX_W       = 5,
  parameter logic [15:0] WIDE_MODS   = 16'h03C0,
  parameter logic [15:0] NARROW_MODS = 16'hFC00,
  parameter int          LIM_MIXED   = 24,
  parameter int          LIM_WIDE    = 20,
  parameter int          LIM_NARROW  = 28,
  parameter logic [15:0] PMASK16     = 16'h7FF7,
  parameter logic [7:0]  PMASK8      = 8'h7E
) (
  input  logic [MOD_W-1:0] mod_i,
  input  logic [IDX_W-1:0] idx_i,
  output reg_attr_t        attr_o
);
  always_comb begin
    attr_o = attr_of(int'(mod_i), int'(idx_i), WIDE_MODS, NARROW_MODS,
                     LIM_MIXED, LIM_WIDE, LIM_NARROW, PMASK16, PMASK8);
  end
endmodule

// File: rtl/regmove_modscan.sv
module regmove_modscan
  import regmove_pkg::*;
#(
  parameter int          NMOD        = 16,
  parameter int          NREG        = 32,
  parameter logic [15:0] WIDE_MODS   = 16'h03C0,
  parameter logic [15:0] NARROW_MODS = 16'hFC00,
  parameter int          LIM_MIXED   = 24,
  parameter int          LIM_WIDE    = 20,
  parameter int          LIM_NARROW  = 28,
  parameter logic [15:0] PMASK16     = 16'h7FF7,
  parameter logic [7:0]  PMASK8      = 8'h7E
) (
  output logic [NMOD-1:0] has_narrow_o
);
  for (genvar g = 0; g < NMOD; g++) begin : g_mod
    logic [NREG-1:0] nb;
    for (genvar j = 0; j < NREG; j++) begin : g_slot
      localparam reg_attr_t A = attr_of(g, j, WIDE_MODS, NARROW_MODS,
                                        LIM_MIXED, LIM_WIDE, LIM_NARROW,
                                        PMASK16, PMASK8);
      assign nb[j] = A.defd && !A.wide;
    end
    assign has_narrow_o[g] = |nb;
  end
endmodule

// File: rtl/regmove_prefix.sv
module regmove_prefix (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_i,
  input  logic [7:0] din_i,
  output logic [7:0] val_o,
  output logic       live_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= 8'h00;
      live_o <= 1'b0;
    end else if (we_i) begin
      val_o  <= din_i;
      live_o <= 1'b1;
    end else begin
      val_o  <= 8'h00;
      live_o <= 1'b0;
    end
  end

  assert_pfx_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !live_o |-> (val_o == 8'h00));
endmodule

// File: rtl/regmove_file.sv
module regmove_file
  import regmove_pkg::*;
#(
  parameter int          NMOD        = 16,
  parameter int          NREG        = 32,
  parameter logic [15:0] WIDE_MODS   = 16'h03C0,
  parameter logic [15:0] NARROW_MODS = 16'hFC00,
  parameter int          LIM_MIXED   = 24,
  parameter int          LIM_WIDE    = 20,
  parameter int          LIM_NARROW  = 28,
  parameter logic [15:0] PMASK16     = 16'h7FF7,
  parameter logic [7:0]  PMASK8      = 8'h7E,
  parameter logic [15:0] INIT_SEED   = 16'h5A3C,
  localparam int NENT   = NMOD * NREG,
  localparam int ADDR_W = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [15:0]       rdata_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [15:0]       wdata_i,
  input  logic [15:0]       wmask_i
);
  logic [15:0] mem [NENT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NENT; k++) begin
        reg_attr_t   a;
        logic [15:0] v;
        a = attr_of(k / NREG, k % NREG, WIDE_MODS, NARROW_MODS,
                    LIM_MIXED, LIM_WIDE, LIM_NARROW, PMASK16, PMASK8);
        v = init_of(k / NREG, k % NREG, INIT_SEED);
        mem[k] <= v & a.mask;
      end
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i & wmask_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
  import regmove_pkg::*;
#(
  parameter int          NMOD        = 16,
  parameter int          NREG        = 32,
  parameter int          WR1_LIM     = 8,
  parameter int          RD1_LIM     = 16,
  parameter logic [15:0] WIDE_MODS   = 16'h03C0,
  parameter logic [15:0] NARROW_MODS = 16'hFC00,
  parameter int          LIM_MIXED   = 24,
  parameter int          LIM_WIDE    = 20,
  parameter int          LIM_NARROW  = 28,
  parameter logic [15:0] PMASK16     = 16'h7FF7,
  parameter logic [7:0]  PMASK8      = 8'h7E,
  parameter logic [15:0] INIT_SEED   = 16'h5A3C,
  localparam int MOD_W  = $clog2(NMOD),
  localparam int IDX_W  = $clog2(NREG),
  localparam int ADDR_W = MOD_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfx_we,
  input  logic [7:0]       pfx_din,
  input  logic             mv_valid,
  input  logic [MOD_W-1:0] src_mod,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [MOD_W-1:0] dst_mod,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             mv_ready,
  output logic             mv_done,
  output logic [15:0]      mv_data
);
  logic [7:0]       pfx_val;
  logic             pfx_live;
  logic             busy_q;
  logic [MOD_W-1:0] op_sm, op_dm;
  logic [IDX_W-1:0] op_si, op_di;
  logic [7:0]       op_pfx;

  logic             accept, need2, stall, exec;
  logic [MOD_W-1:0] cur_sm, cur_dm;
  logic [IDX_W-1:0] cur_si, cur_di;
  logic [7:0]       cur_pfx;
  reg_attr_t        s_attr, d_attr;
  logic [NMOD-1:0]  has_narrow;
  logic [15:0]      rdata, src_word, wr_data;
  logic             wr_en;

  regmove_prefix u_pfx (
    .clk(clk), .rst(rst), .we_i(pfx_we), .din_i(pfx_din),
    .val_o(pfx_val), .live_o(pfx_live)
  );

  assign accept = mv_valid && !busy_q;
  assign need2  = (int'(dst_idx) >= WR1_LIM) || (int'(src_idx) >= RD1_LIM);
  assign stall  = accept && need2 && !pfx_live;
  assign exec   = busy_q || (accept && !stall);

  assign cur_sm  = busy_q ? op_sm  : src_mod;
  assign cur_si  = busy_q ? op_si  : src_idx;
  assign cur_dm  = busy_q ? op_dm  : dst_mod;
  assign cur_di  = busy_q ? op_di  : dst_idx;
  assign cur_pfx = busy_q ? op_pfx : pfx_val;

  regmove_attr #(
    .MOD_W(MOD_W), .IDX_W(IDX_W), .WIDE_MODS(WIDE_MODS),
    .NARROW_MODS(NARROW_MODS), .LIM_MIXED(LIM_MIXED), .LIM_WIDE(LIM_WIDE),
    .LIM_NARROW(LIM_NARROW), .PMASK16(PMASK16), .PMASK8(PMASK8)
  ) u_src_attr (.mod_i(cur_sm), .idx_i(cur_si), .attr_o(s_attr));

  regmove_attr #(
    .MOD_W(MOD_W), .IDX_W(IDX_W), .WIDE_MODS(WIDE_MODS),
    .NARROW_MODS(NARROW_MODS), .LIM_MIXED(LIM_MIXED), .LIM_WIDE(LIM_WIDE),
    .LIM_NARROW(LIM_NARROW), .PMASK16(PMASK16), .PMASK8(PMASK8)
  ) u_dst_attr (.mod_i(cur_dm), .idx_i(cur_di), .attr_o(d_attr));

  regmove_modscan #(
    .NMOD(NMOD), .NREG(NREG), .WIDE_MODS(WIDE_MODS),
    .NARROW_MODS(NARROW_MODS), .LIM_MIXED(LIM_MIXED), .LIM_WIDE(LIM_WIDE),
    .LIM_NARROW(LIM_NARROW), .PMASK16(PMASK16), .PMASK8(PMASK8)
  ) u_scan (.has_narrow_o(has_narrow));

  regmove_file #(
    .NMOD(NMOD), .NREG(NREG), .WIDE_MODS(WIDE_MODS),
    .NARROW_MODS(NARROW_MODS), .LIM_MIXED(LIM_MIXED), .LIM_WIDE(LIM_WIDE),
    .LIM_NARROW(LIM_NARROW), .PMASK16(PMASK16), .PMASK8(PMASK8),
    .INIT_SEED(INIT_SEED)
  ) u_file (
    .clk(clk), .rst(rst),
    .raddr_i({cur_sm, cur_si}), .rdata_o(rdata),
    .we_i(wr_en), .waddr_i({cur_dm, cur_di}),
    .wdata_i(wr_data), .wmask_i(d_attr.mask)
  );

  always_comb begin
    if (s_attr.defd)
      src_word = s_attr.wide ? rdata : {cur_pfx, rdata[7:0]};
    else if (has_narrow[cur_sm])
      src_word = {cur_pfx, 8'h00};
    else
      src_word = 16'h0000;
  end

  assign wr_en   = exec && d_attr.defd;
  assign wr_data = d_attr.wide ? src_word : {8'h00, src_word[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      mv_done <= 1'b0;
      mv_data <= 16'h0000;
      op_sm   <= '0;
      op_si   <= '0;
      op_dm   <= '0;
      op_di   <= '0;
      op_pfx  <= 8'h00;
    end else begin
      busy_q  <= stall;
      mv_done <= exec;
      if (stall) begin
        op_sm  <= src_mod;
        op_si  <= src_idx;
        op_dm  <= dst_mod;
        op_di  <= dst_idx;
        op_pfx <= 8'h00;
      end
      if (exec)
        mv_data <= src_word;
    end
  end

  assign mv_ready = !busy_q;

  assert_stall_completes_R8: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (mv_done && !busy_q));

  assert_undef_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !s_attr.defd |-> (rdata == 16'h0000));

  assert_unimpl_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~s_attr.mask) == 16'h0000);

  assert_widen_hi_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (exec && s_attr.defd && !s_attr.wide && d_attr.wide)
      |-> (wr_data[15:8] == cur_pfx));

  assert_stall_drops_pfx_R10: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cur_pfx == 8'h00));
endmodule

// File: tb/regmove_unit_test.sv
module regmove_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pfx_we = 1'b0;
  logic [7:0]  pfx_din = 8'h00;
  logic        mv_valid = 1'b0;
  logic [3:0]  src_mod = '0, dst_mod = '0;
  logic [4:0]  src_idx = '0, dst_idx = '0;
  logic        mv_ready, mv_done;
  logic [15:0] mv_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  regmove_unit uut (
    .clk(clk), .rst(rst), .pfx_we(pfx_we), .pfx_din(pfx_din),
    .mv_valid(mv_valid), .src_mod(src_mod), .src_idx(src_idx),
    .dst_mod(dst_mod), .dst_idx(dst_idx),
    .mv_ready(mv_ready), .mv_done(mv_done), .mv_data(mv_data)
  );

  // ---- behavioural reference (layout per R11, masks per R5, init per R1)
  function automatic int kind_of(int m);  // 0 mixed, 1 wide-only, 2 narrow-only
    if (m < 6) return 0;
    if (m < 10) return 1;
    return 2;
  endfunction
  function automatic bit b_defd(int m, int i);
    int k = kind_of(m);
    return (k == 0) ? (i < 24) : (k == 1) ? (i < 20) : (i < 28);
  endfunction
  function automatic bit b_wide(int m, int i);
    int k = kind_of(m);
    return (k == 1) || (k == 0 && (i % 2 == 1));
  endfunction
  function automatic logic [15:0] b_mask(int m, int i);
    if (!b_defd(m, i)) return 16'h0;
    if (b_wide(m, i)) return (i % 4 == 3) ? 16'h7FF7 : 16'hFFFF;
    return (i % 4 == 3) ? 16'h007E : 16'h00FF;
  endfunction
  function automatic logic [15:0] b_init(int m, int i);
    int v = (32'h5A3C + 32'h0111 * m + 32'h1013 * i) % 65536;
    return 16'(v) & b_mask(m, i);
  endfunction

  logic [15:0] mdl [16][32];
  bit          m_busy, m_pl, e_done, e_ready;
  logic [7:0]  m_pv;
  logic [15:0] e_data;
  int          p_sm, p_si, p_dm, p_di;

  task automatic m_exec(int sm, int si, int dm, int di, logic [7:0] p);
    logic [15:0] w;
    if (b_defd(sm, si))
      w = b_wide(sm, si) ? mdl[sm][si] : {p, mdl[sm][si][7:0]};
    else
      w = (kind_of(sm) == 1) ? 16'h0000 : {p, 8'h00};
    if (b_defd(dm, di))
      mdl[dm][di] = (b_wide(dm, di) ? w : {8'h00, w[7:0]}) & b_mask(dm, di);
    e_data = w;
    e_done = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < 16; m++)
        for (int i = 0; i < 32; i++) mdl[m][i] = b_init(m, i);
      m_busy = 0; m_pl = 0; m_pv = 0; e_done = 0; e_ready = 1;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_exec(p_sm, p_si, p_dm, p_di, 8'h00);
        m_busy = 0;
      end else if (mv_valid) begin
        if ((dst_idx >= 8 || src_idx >= 16) && !m_pl) begin
          m_busy = 1;
          p_sm = src_mod; p_si = src_idx; p_dm = dst_mod; p_di = dst_idx;
        end else
          m_exec(src_mod, src_idx, dst_mod, dst_idx, m_pl ? m_pv : 8'h00);
      end
      if (pfx_we) begin m_pv = pfx_din; m_pl = 1; end
      else begin m_pv = 0; m_pl = 0; end
      e_ready = !m_busy;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_tests++;
      if (mv_done !== e_done || mv_ready !== e_ready ||
          (e_done && mv_data !== e_data)) begin
        n_fail++;
        $display("FAIL R8 per-cycle: done/ready/data act %b/%b/%h exp %b/%b/%h",
                 mv_done, mv_ready, mv_data, e_done, e_ready, e_data);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic mv(int sm, int si, int dm, int di, bit use_p, logic [7:0] pv,
                    int gap, output logic [15:0] x, output int cyc);
    if (use_p) begin
      @(posedge clk); #1 pfx_we = 1; pfx_din = pv;
      @(posedge clk); #1 pfx_we = 0;
      repeat (gap) @(posedge clk);
      if (gap > 0) #1;
    end else begin
      @(posedge clk); #1;
    end
    mv_valid = 1; src_mod = 4'(sm); src_idx = 5'(si);
    dst_mod = 4'(dm); dst_idx = 5'(di);
    @(posedge clk); #1 mv_valid = 0;
    cyc = 1;
    @(negedge clk);
    while (!mv_done && cyc < 5) begin cyc++; @(negedge clk); end
    x = mv_data;
  endtask

  // read a register by moving it into an absent slot (module 6, index 31)
  task automatic rd(int m, int i, output logic [15:0] x);
    int c;
    mv(m, i, 6, 31, 0, 8'h00, 0, x, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act hung exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] x;
    int c;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 ready after reset", 16'(mv_ready), 16'h1);
    chk("R1 done after reset", 16'(mv_done), 16'h0);
    rd(0, 1, x);  chk("R1 init mixed wide", x, b_init(0, 1));
    rd(12, 4, x); chk("R1 init narrow", x, b_init(12, 4));

    // R2
    mv(6, 2, 6, 4, 0, 0, 0, x, c);
    rd(6, 4, x);  chk("R2 16->16 copy", x, b_init(6, 2));
    mv(10, 1, 10, 5, 0, 0, 0, x, c);
    rd(10, 5, x); chk("R2 8->8 copy", x, b_init(10, 1));

    // R3
    mv(0, 0, 0, 1, 1, 8'hC3, 0, x, c);
    rd(0, 1, x);  chk("R3 widen with prefix", x, {8'hC3, b_init(0, 0)[7:0]});
    mv(0, 2, 0, 5, 0, 0, 0, x, c);
    rd(0, 5, x);  chk("R3 widen no prefix", x, {8'h00, b_init(0, 2)[7:0]});

    // R4
    mv(6, 5, 10, 6, 0, 0, 0, x, c);
    rd(10, 6, x); chk("R4 narrow keeps low byte", x, {8'h00, b_init(6, 5)[7:0]});

    // R5
    mv(6, 1, 6, 3, 0, 0, 0, x, c);
    rd(6, 3, x);  chk("R5 wide mask", x, b_init(6, 1) & 16'h7FF7);
    mv(10, 0, 10, 7, 0, 0, 0, x, c);
    rd(10, 7, x); chk("R5 narrow mask", x, {8'h00, b_init(10, 0)[7:0] & 8'h7E});

    // R6
    mv(6, 0, 7, 25, 0, 0, 0, x, c);
    chk("R6 data to absent dest", x, b_init(6, 0));
    rd(7, 25, x); chk("R6 absent dest unchanged", x, 16'h0000);
    rd(6, 0, x);  chk("R6 source intact", x, b_init(6, 0));

    // R7
    mv(0, 30, 6, 31, 1, 8'h5A, 0, x, c); chk("R7 absent in mixed", x, 16'h5A00);
    mv(11, 29, 6, 31, 1, 8'h5A, 0, x, c); chk("R7 absent in narrow", x, 16'h5A00);
    mv(8, 25, 6, 31, 1, 8'h5A, 0, x, c); chk("R7 absent in wide-only", x, 16'h0000);
    mv(0, 26, 7, 0, 1, 8'h77, 0, x, c);
    rd(7, 0, x);  chk("R7 absent source written", x, 16'h7700);

    // R8
    mv(6, 0, 6, 1, 0, 0, 0, x, c);  chk("R8 one-cycle move", 16'(c), 16'd1);
    mv(6, 0, 6, 9, 0, 0, 0, x, c);  chk("R8 two-cycle by dest", 16'(c), 16'd2);
    mv(6, 17, 6, 2, 0, 0, 0, x, c); chk("R8 two-cycle by source", 16'(c), 16'd2);
    chk("R8 data from index 17", x, b_init(6, 17));

    // R9
    mv(6, 17, 6, 10, 1, 8'h11, 0, x, c); chk("R9 prefix absorbs cycle", 16'(c), 16'd1);
    rd(6, 10, x); chk("R9 data moved", x, b_init(6, 17));

    // R10
    mv(0, 4, 0, 7, 1, 8'hE5, 1, x, c);
    rd(0, 7, x);  chk("R10 prefix expired", x, {8'h00, b_init(0, 4)[7:0]} & 16'h7FF7);
    mv(12, 16, 0, 9, 1, 8'hB2, 2, x, c);
    rd(0, 9, x);  chk("R10 stalled move sees zero", x, {8'h00, b_init(12, 16)[7:0]});
    mv(12, 2, 6, 31, 1, 8'h3D, 0, x, c); chk("R11 narrow module read", x, {8'h3D, b_init(12, 2)[7:0]});

    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule